// File: doc/BRIEF.md
# Three-Wire Serial Control Bus Slave

This block is the slave end of a three-wire control bus. The host drives an active-low select and a bit clock, and the two sides share one data line. The line is modelled here as a separate input, output and output enable, so the pad and its tristate stay outside the block.

Each frame opens with a 9-bit header that carries a device number, a direction bit and a register index. A 16-bit data word follows. On a write the slave shifts the word in. On a read it shifts the word out. The shift counter re-arms after every word, so one select window can hold any number of frames.

The host's clock, data and select are sampled into the system clock domain through two-flop synchronizers. Bus clock edges are detected there. The inside of the block sees a plain register port: device number, register index, direction flag, write data with a one-cycle write strobe, and a one-cycle read strobe. The read data is sampled one system cycle after the read strobe.

Top module: `serial_ctl_slave`

## Requirements
- R1: After reset, the output enable, the write strobe, the read strobe and the error flag are all low.
- R2: A header is 9 bits, most significant bit first. Bits 8:6 are the device number, bit 5 is the direction (1 = read, 0 = write) and bits 4:0 are the register index. When the header completes, these fields are presented on the register port outputs.
- R3: On a write, the slave takes 16 data bits, most significant first, one per rising bus clock edge. It raises the write strobe with the assembled word only after the 16th bit, and never earlier.
- R4: On a read, the slave pulses the read strobe as soon as the header completes and samples the read data one system cycle later. It then presents one bit per rising bus clock edge on the data output, most significant bit first.
- R5: The output enable is high only for a read whose device number matches the configured one. It rises when the header completes and stays high until the first rising edge after the last data bit, or until select goes high.
- R6: A header whose device number differs from the configured one raises the error flag for one cycle. That frame produces no write strobe, no read strobe and no output enable, but its 16 data bits are still counted.
- R7: After a data word completes, the next rising edge starts a new header without select being toggled.
- R8: Select going high during a partial frame discards it with no strobe. The next frame after select falls is decoded from a fresh header.
- R9: Bus clock edges while select is high have no effect.
- R10: The write strobe, read strobe and error flag are each one system cycle wide, and the write and read strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_dev | input | 3 | Device number this slave answers to |
| bus_sel_n | input | 1 | Bus select, active low |
| bus_clk | input | 1 | Bus bit clock from the host |
| bus_din | input | 1 | Data line as seen by the slave |
| bus_dout | output | 1 | Data bit driven during reads |
| bus_doe | output | 1 | Enable for the data line driver |
| reg_dev | output | 3 | Device number from the last header |
| reg_idx | output | 5 | Register index from the last header |
| reg_rnw | output | 1 | Direction from the last header, 1 = read |
| reg_wdata | output | 16 | Word received by a write |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 16 | Read word, sampled the cycle after reg_rd |
| err_nodev | output | 1 | One-cycle pulse on a device number mismatch |

## Verification
Two situations are the hardest to reach from the ports. The first is a frame cut off part way through, which must leave no trace. The bench reaches it by dropping select after a header and seven data bits, then running a full write and checking that only the clean frame produces a strobe and carries its own fields. The second is framing that re-arms without select. The bench reaches it by running a write and then a read inside one select window and checking the index and data of both. A burst of bus clocks with select high, each clock carrying data, shows that nothing is decoded from edges that arrive outside a select window.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  localparam int HDR_BITS = 9;
  localparam int DATA_W   = 16;
  localparam int DEV_W    = 3;
  localparam int IDX_W    = 5;
  localparam int CNT_W    = $clog2(DATA_W);

  typedef enum logic {
    PH_HDR  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/ssl_sync.sv
module ssl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssl_edge.sv
module ssl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/ssl_frame.sv
module ssl_frame
  import ssl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_hi_i,
  input  logic              rise_i,
  input  logic              din_i,
  input  logic [DEV_W-1:0]  my_dev_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DEV_W-1:0]  dev_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              rnw_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              err_o,
  output logic              dout_o,
  output logic              doe_o
);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  phase_e            phase_q, phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] shr_q, shr_n, shifted;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic [DEV_W-1:0]  dev_q, dev_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              rnw_q, rnw_n, hit_q, hit_n;
  logic              drive_q, drive_n, dout_q, dout_n, ld_q, ld_n;
  logic              wr_q, wr_n, rd_q, rd_n, err_q, err_n;
  logic [HDR_BITS-1:0] hdr;

  assign shifted = {shr_q[DATA_W-2:0], din_i};
  assign hdr     = shifted[HDR_BITS-1:0];

  always_comb begin
    phase_n = phase_q; cnt_n = cnt_q; shr_n = shr_q; wdata_n = wdata_q;
    dev_n = dev_q; idx_n = idx_q; rnw_n = rnw_q; hit_n = hit_q;
    drive_n = drive_q; dout_n = dout_q;
    ld_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; err_n = 1'b0;
    if (ld_q) shr_n = rdata_i;
    if (sel_hi_i) begin
      phase_n = PH_HDR; cnt_n = HDR_LAST; shr_n = '0; drive_n = 1'b0;
    end else if (rise_i) begin
      if (phase_q == PH_HDR) begin
        shr_n = shifted;
        if (cnt_q == '0) begin
          dev_n   = hdr[HDR_BITS-1 -: DEV_W];
          rnw_n   = hdr[IDX_W];
          idx_n   = hdr[IDX_W-1:0];
          hit_n   = (hdr[HDR_BITS-1 -: DEV_W] == my_dev_i);
          phase_n = PH_DATA; cnt_n = DATA_LAST; shr_n = '0;
          err_n   = !hit_n;
          rd_n    = hit_n & rnw_n;
          ld_n    = rd_n;
          drive_n = rd_n;
          dout_n  = 1'b0;
        end else begin
          cnt_n   = cnt_q - 1'b1;
          drive_n = 1'b0;
        end
      end else begin
        if (rnw_q) dout_n = shr_q[cnt_q];
        else       shr_n  = shifted;
        if (cnt_q == '0) begin
          phase_n = PH_HDR; cnt_n = HDR_LAST; shr_n = '0;
          if (!rnw_q) begin
            wdata_n = shifted;
            wr_n    = hit_q;
          end
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HDR; cnt_q <= HDR_LAST; shr_q <= '0; wdata_q <= '0;
      dev_q <= '0; idx_q <= '0; rnw_q <= 1'b0; hit_q <= 1'b0;
      drive_q <= 1'b0; dout_q <= 1'b0; ld_q <= 1'b0;
      wr_q <= 1'b0; rd_q <= 1'b0; err_q <= 1'b0;
    end else begin
      phase_q <= phase_n; cnt_q <= cnt_n; shr_q <= shr_n; wdata_q <= wdata_n;
      dev_q <= dev_n; idx_q <= idx_n; rnw_q <= rnw_n; hit_q <= hit_n;
      drive_q <= drive_n; dout_q <= dout_n; ld_q <= ld_n;
      wr_q <= wr_n; rd_q <= rd_n; err_q <= err_n;
    end
  end

  assign dev_o = dev_q;  assign idx_o = idx_q;  assign rnw_o = rnw_q;
  assign wdata_o = wdata_q;
  assign wr_o = wr_q;  assign rd_o = rd_q;  assign err_o = err_q;
  assign dout_o = dout_q;  assign doe_o = drive_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_q && rd_q)); // R10
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q); // R10
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q); // R6
  AST_OE_ON_HIT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> (hit_q && rnw_q)); // R5
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hi_i |=> (!wr_q && !rd_q && !drive_q)); // R8
  AST_HDR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HDR) |-> (cnt_q <= HDR_LAST)); // R2
endmodule

// File: rtl/serial_ctl_slave.sv
module serial_ctl_slave
  import ssl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  my_dev,
  input  logic              bus_sel_n,
  input  logic              bus_clk,
  input  logic              bus_din,
  output logic              bus_dout,
  output logic              bus_doe,
  output logic [DEV_W-1:0]  reg_dev,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              reg_rnw,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              err_nodev
);
  logic [1:0] rst_q;
  logic       rst_sn;
  logic [2:0] pins_s;
  logic       clk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  // pins_s = {select, clock, data}; select idles high
  ssl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_sn),
    .d_i({bus_sel_n, bus_clk, bus_din}), .q_o(pins_s)
  );

  ssl_edge u_edge (
    .clk(clk), .rst_n(rst_sn), .lvl_i(pins_s[1]), .rise_o(clk_rise)
  );

  ssl_frame u_frame (
    .clk(clk), .rst_n(rst_sn),
    .sel_hi_i(pins_s[2]), .rise_i(clk_rise), .din_i(pins_s[0]),
    .my_dev_i(my_dev), .rdata_i(reg_rdata),
    .dev_o(reg_dev), .idx_o(reg_idx), .rnw_o(reg_rnw),
    .wdata_o(reg_wdata), .wr_o(reg_wr), .rd_o(reg_rd), .err_o(err_nodev),
    .dout_o(bus_dout), .doe_o(bus_doe)
  );
endmodule

// File: tb/serial_ctl_slave_tb.sv
module serial_ctl_slave_tb;
  localparam int H = 6;
  localparam logic [2:0] ME = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel_n = 1'b1, bus_clk = 1'b0, bus_din = 1'b0;
  logic bus_dout, bus_doe, reg_rnw, reg_wr, reg_rd, err_nodev;
  logic [2:0] reg_dev;
  logic [4:0] reg_idx;
  logic [15:0] reg_wdata, reg_rdata;

  int n_tests = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, err_cnt = 0;
  logic [15:0] rx;
  int oe_hi;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] rmod(input logic [4:0] i);
    return {i, ~i, 6'h2B};
  endfunction
  assign reg_rdata = rmod(reg_idx);

  serial_ctl_slave u_dut (
    .clk(clk), .rst_n(rst_n), .my_dev(ME),
    .bus_sel_n(bus_sel_n), .bus_clk(bus_clk), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_doe(bus_doe),
    .reg_dev(reg_dev), .reg_idx(reg_idx), .reg_rnw(reg_rnw),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .err_nodev(err_nodev)
  );

  always @(negedge clk) begin
    if (reg_wr) wr_cnt++;
    if (reg_rd) rd_cnt++;
    if (err_nodev) err_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic b);
    bus_din = b;
    wait_n(H);
    bus_clk = 1'b1;
    wait_n(H);
    rx = {rx[14:0], bus_dout};
    if (bus_doe) oe_hi++;
    bus_clk = 1'b0;
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  task automatic sel(input logic lvl);
    bus_sel_n = lvl;
    wait_n(H);
  endtask

  function automatic logic [8:0] hdr(input logic [2:0] d, input logic r, input logic [4:0] i);
    return {d, r, i};
  endfunction

  task automatic t_reset;
    chk(bus_doe == 0, "R1 oe", bus_doe, 0);
    chk({reg_wr, reg_rd, err_nodev} == 0, "R1 strobes", {reg_wr, reg_rd, err_nodev}, 0);
  endtask

  task automatic t_write(input logic [4:0] idx, input logic [15:0] d);
    int w0;
    w0 = wr_cnt;
    sel(0);
    send({7'd0, hdr(ME, 0, idx)}, 9);
    chk(reg_dev == ME && reg_idx == idx && reg_rnw == 0, "R2 fields",
        {reg_dev, reg_idx, reg_rnw}, {ME, idx, 1'b0});
    send(d >> 1, 15);
    chk(wr_cnt == w0, "R3 no early strobe", wr_cnt, w0);
    tick(d[0]);
    chk(wr_cnt == w0 + 1, "R10 single strobe", wr_cnt, w0 + 1);
    chk(reg_wdata == d, "R3 write data", reg_wdata, d);
    sel(1);
  endtask

  task automatic t_read(input logic [4:0] idx);
    int r0;
    r0 = rd_cnt;
    sel(0);
    send({7'd0, hdr(ME, 1, idx)}, 9);
    chk(rd_cnt == r0 + 1, "R4 read strobe", rd_cnt, r0 + 1);
    chk(reg_rnw == 1 && reg_idx == idx, "R2 read fields", {reg_rnw, reg_idx}, {1'b1, idx});
    oe_hi = 0;
    send(16'h0, 16);
    chk(rx == rmod(idx), "R4 read data", rx, rmod(idx));
    chk(oe_hi == 16, "R5 oe during data", oe_hi, 16);
    sel(1);
    chk(bus_doe == 0, "R5 oe off after select", bus_doe, 0);
  endtask

  task automatic t_mismatch;
    int w0, r0, e0;
    w0 = wr_cnt; r0 = rd_cnt; e0 = err_cnt;
    sel(0);
    oe_hi = 0;
    send({7'd0, hdr(3'd2, 1, 5'd4)}, 9);
    send(16'hFFFF, 16);
    send({7'd0, hdr(3'd6, 0, 5'd4)}, 9);
    send(16'h1234, 16);
    sel(1);
    chk(err_cnt == e0 + 2, "R6 error pulses", err_cnt, e0 + 2);
    chk(wr_cnt == w0 && rd_cnt == r0, "R6 no strobes", wr_cnt + rd_cnt, w0 + r0);
    chk(oe_hi == 0, "R6 oe stays low", oe_hi, 0);
  endtask

  task automatic t_back_to_back;
    int w0;
    w0 = wr_cnt;
    sel(0);
    send({7'd0, hdr(ME, 0, 5'd9)}, 9);
    send(16'hC3A5, 16);
    chk(wr_cnt == w0 + 1 && reg_wdata == 16'hC3A5, "R7 first frame", reg_wdata, 16'hC3A5);
    send({7'd0, hdr(ME, 1, 5'd17)}, 9);
    chk(reg_idx == 5'd17 && reg_rnw, "R7 second header", reg_idx, 17);
    oe_hi = 0;
    send(16'h0, 16);
    chk(rx == rmod(5'd17), "R7 second frame data", rx, rmod(5'd17));
    send({7'd0, hdr(ME, 0, 5'd1)}, 1);
    chk(bus_doe == 0, "R5 oe off after next rise", bus_doe, 0);
    sel(1);
  endtask

  task automatic t_abort;
    int w0;
    w0 = wr_cnt;
    sel(0);
    send({7'd0, hdr(ME, 0, 5'd3)}, 9);
    send(16'h00FF, 7);
    sel(1);
    chk(wr_cnt == w0, "R8 aborted frame silent", wr_cnt, w0);
    sel(0);
    send({7'd0, hdr(ME, 0, 5'd12)}, 9);
    send(16'h5A0F, 16);
    sel(1);
    chk(wr_cnt == w0 + 1 && reg_idx == 5'd12 && reg_wdata == 16'h5A0F,
        "R8 fresh frame", reg_wdata, 16'h5A0F);
  endtask

  task automatic t_idle_clocks;
    int w0, r0, e0;
    w0 = wr_cnt; r0 = rd_cnt; e0 = err_cnt;
    send(16'hFFFF, 16);
    send(16'h2A5A, 16);
    chk(wr_cnt == w0 && rd_cnt == r0 && err_cnt == e0, "R9 ignored clocks",
        wr_cnt + rd_cnt + err_cnt, w0 + r0 + e0);
    t_write(5'd7, 16'h8001);
    chk(reg_idx == 5'd7, "R9 next frame aligned", reg_idx, 7);
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(6);
    t_reset();
    t_write(5'd22, 16'hBEEF);
    t_read(5'd22);
    t_mismatch();
    t_back_to_back();
    t_abort();
    t_idle_clocks();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule